// File: doc/BRIEF.md
# Static Memory Chip-Select Sequencer

This block turns simple internal bus requests into the chip-select, output-enable and write-enable strobes needed by external static memories such as ROM, flash and SRAM. Each memory region has its own configuration byte. That byte sets the wait states for random and sequential accesses, a page-mode enable, a flag for writable devices and the data width. The sequencer keeps a region's chip-select asserted across back-to-back accesses. When page mode is on, it gives shorter sequential timing to accesses that continue the previous address.

Chip-select is always released after four accesses in a row, even when page mode is off, so that other bus masters such as DMA and refresh can get in. An external ready input can stretch any access beyond its programmed wait states. The data width of region 0, the boot region, is taken from two strap pins while reset is asserted. Each access that finishes produces a single done pulse. For reads, the captured data is on `rdata` in that same cycle.

Top module: `smc_strobe_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every `cs_n` bit, `oe_n` and `we_n` are high and `done` is low.
- R2: The region 0 width is taken from `boot_strap` while `rst` is high and is held from the last reset cycle. Code 01 means 1 byte, code 10 means 2 bytes, and codes 00 and 11 mean 4 bytes. The width field in region 0's configuration byte is ignored, and strap changes after reset have no effect.
- R3: A configuration write of `cfg_wdata` to region `cfg_sel` loads the fields as follows: bits [1:0] random wait, [3:2] sequential wait, [4] page enable, [5] writable device, [7:6] width code (same coding as R2). After reset, every region has random wait 3, sequential wait 3, page off, not writable, 4-byte width.
- R4: An access asserts exactly one strobe: `oe_n` for a read, `we_n` for a write. That strobe stays low for wait+1 cycles when `mem_ready` is high. `mem_addr` and, for writes, `mem_wdata` hold the request values while the strobe is low, and the region's `cs_n` bit is low during that time.
- R5: An access is sequential when all of these hold: page mode is enabled, chip-select is still held from an earlier access, the region is the same, and the address equals the previous address plus the width in bytes. A sequential access uses the sequential wait. Every other access uses the random wait.
- R6: With page mode disabled, every access uses the random wait.
- R7: For a region flagged writable, a sequential wait field of 0 is applied as 1 wait state. For a region not flagged writable, 0 is applied as 0.
- R8: Between accesses to the same region, chip-select stays low. After the fourth access in a row, all `cs_n` bits are high in that access's done cycle. The access that follows starts a new burst with random timing.
- R9: While `mem_ready` is low after the wait states have run out, the access does not complete. The strobe and `mem_addr` do not change during this extension.
- R10: `done` is high for exactly one cycle per access, in the cycle after the strobe returns high. For reads, `rdata` in that cycle holds the `mem_rdata` value present at the last strobe cycle.
- R11: At most one `cs_n` bit is low at any time. A request to a different region first releases chip-select for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 2 | Boot width strap pins, taken while reset is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | RW | Region selected for a configuration write |
| cfg_wdata | input | 8 | Configuration byte |
| req | input | 1 | Access request, held until `done` |
| req_region | input | RW | Region of the request |
| req_addr | input | AW | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid with `done` |
| cs_n | output | NREG | Active-low chip-selects, one per region |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory ready; low stretches the access |

## Verification
A wrong wait counter or a wrong wait selection shows up in the strobe length of the very access affected. A corrupted previous-address or region register has the same effect: the next access that should be sequential runs with random length instead. A burst counter that is off by one shows at the ports no later than the fourth done pulse of a burst: chip-select is released a cycle early or late, or the following access gets the wrong timing class. A wrong boot-width capture only shows once the first sequential access to region 0 is made, through the length of its strobe.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WAIT_W = 2;

  typedef struct packed {
    logic [1:0]        width;
    logic              wr_dev;
    logic              page;
    logic [WAIT_W-1:0] seq_w;
    logic [WAIT_W-1:0] rnd_w;
  } smc_cfg_t;

  localparam int CFG_W = $bits(smc_cfg_t);

  localparam smc_cfg_t CFG_RESET = '{width: 2'b00, wr_dev: 1'b0, page: 1'b0,
                                     seq_w: 2'b11, rnd_w: 2'b11};

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_END, ST_OPEN} smc_state_e;

  // bytes per bus word for a width code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'b01:   width_bytes = 3'd1;
      2'b10:   width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/smc_cfg_bank.sv
module smc_cfg_bank
  import smc_pkg::*;
#(
  parameter int NREG = 2,
  parameter int RW   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    boot_strap,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_sel,
  input  smc_cfg_t      cfg_wdata,
  input  logic [RW-1:0] rd_sel,
  output smc_cfg_t      cfg_o
);
  smc_cfg_t   cfg_q [NREG];
  logic [1:0] boot_code;

  // strap follows the pins while reset is high, frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) boot_code <= boot_strap;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst)                                cfg_q[g] <= CFG_RESET;
      else if (cfg_we && cfg_sel == RW'(g))   cfg_q[g] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_o = CFG_RESET;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel == RW'(i)) cfg_o = cfg_q[i];
    end
    if (rd_sel == '0) cfg_o.width = boot_code;
  end
endmodule

// File: rtl/smc_seq_detect.sv
module smc_seq_detect
  import smc_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 1
) (
  input  smc_cfg_t          cfg_i,
  input  logic              open_i,
  input  logic [RW-1:0]     req_region,
  input  logic [AW-1:0]     req_addr,
  input  logic [RW-1:0]     last_region,
  input  logic [AW-1:0]     last_addr,
  output logic [WAIT_W-1:0] acc_wait
);
  logic [AW-1:0]     next_addr;
  logic [WAIT_W-1:0] seq_eff;
  logic              hit;

  assign next_addr = last_addr + AW'(width_bytes(cfg_i.width));

  // a write-strobed device never gets zero sequential waits
  assign seq_eff = (cfg_i.wr_dev && cfg_i.seq_w == '0) ? WAIT_W'(1) : cfg_i.seq_w;

  assign hit = open_i && cfg_i.page && (req_region == last_region) &&
               (req_addr == next_addr);

  assign acc_wait = hit ? seq_eff : cfg_i.rnd_w;
endmodule

// File: rtl/smc_cycle_fsm.sv
module smc_cycle_fsm
  import smc_pkg::*;
#(
  parameter int NREG      = 2,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int RW        = 1,
  parameter int BURST_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [RW-1:0]     req_region,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  input  logic [WAIT_W-1:0] acc_wait,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  output logic [NREG-1:0]   cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              open_o,
  output logic [RW-1:0]     last_region,
  output logic [AW-1:0]     last_addr
);
  localparam int BC_W = $clog2(BURST_MAX + 1);

  smc_state_e        st;
  logic [WAIT_W-1:0] wcnt;
  logic [BC_W-1:0]   bcnt;
  logic              wr_q;
  logic [RW-1:0]     cur_region;
  logic              same_region;
  logic              burst_full;
  logic              start_acc;

  assign same_region = (req_region == cur_region);
  assign burst_full  = (bcnt == BC_W'(BURST_MAX));
  assign start_acc   = req && ((st == ST_IDLE) || (st == ST_OPEN && same_region));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cs_n       <= '1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      done       <= 1'b0;
      wcnt       <= '0;
      bcnt       <= '0;
      wr_q       <= 1'b0;
      cur_region <= '0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rdata      <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        st         <= ST_ACC;
        cur_region <= req_region;
        mem_addr   <= req_addr;
        mem_wdata  <= req_wdata;
        wr_q       <= req_write;
        cs_n       <= ~(NREG'(1) << req_region);
        oe_n       <= req_write;
        we_n       <= ~req_write;
        wcnt       <= acc_wait;
        bcnt       <= (st == ST_IDLE) ? BC_W'(1) : bcnt + BC_W'(1);
      end else begin
        case (st)
          ST_ACC: begin
            if (wcnt != '0) begin
              wcnt <= wcnt - WAIT_W'(1);
            end else if (mem_ready) begin
              oe_n <= 1'b1;
              we_n <= 1'b1;
              done <= 1'b1;
              if (!wr_q)     rdata <= mem_rdata;
              if (burst_full) cs_n <= '1;
              st <= ST_END;
            end
          end
          ST_END:  st <= burst_full ? ST_IDLE : ST_OPEN;
          ST_OPEN: begin
            // only a request for another region reaches here
            if (req) begin
              cs_n <= '1;
              st   <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign open_o      = (st == ST_OPEN);
  assign last_region = cur_region;
  assign last_addr   = mem_addr;
endmodule

// File: rtl/smc_strobe_seq.sv
module smc_strobe_seq
  import smc_pkg::*;
#(
  parameter  int NREG      = 2,
  parameter  int AW        = 16,
  parameter  int DW        = 32,
  parameter  int BURST_MAX = 4,
  localparam int RW        = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      boot_strap,
  input  logic            cfg_we,
  input  logic [RW-1:0]   cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic            req,
  input  logic [RW-1:0]   req_region,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [NREG-1:0] cs_n,
  output logic            oe_n,
  output logic            we_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready
);
  smc_cfg_t          req_cfg;
  logic              open_s;
  logic [RW-1:0]     last_region;
  logic [AW-1:0]     last_addr;
  logic [WAIT_W-1:0] acc_wait;

  smc_cfg_bank #(.NREG(NREG), .RW(RW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .boot_strap (boot_strap),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (smc_cfg_t'(cfg_wdata)),
    .rd_sel     (req_region),
    .cfg_o      (req_cfg)
  );

  smc_seq_detect #(.AW(AW), .RW(RW)) u_seq (
    .cfg_i       (req_cfg),
    .open_i      (open_s),
    .req_region  (req_region),
    .req_addr    (req_addr),
    .last_region (last_region),
    .last_addr   (last_addr),
    .acc_wait    (acc_wait)
  );

  smc_cycle_fsm #(.NREG(NREG), .AW(AW), .DW(DW), .RW(RW), .BURST_MAX(BURST_MAX)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_region  (req_region),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .acc_wait    (acc_wait),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done        (done),
    .rdata       (rdata),
    .open_o      (open_s),
    .last_region (last_region),
    .last_addr   (last_addr)
  );
endmodule

// File: rtl/smc_strobe_seq_chk.sv
module smc_strobe_seq_chk #(
  parameter int NREG      = 2,
  parameter int AW        = 16,
  parameter int BURST_MAX = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] cs_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            done,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr
);
  logic       strobe_low;
  logic       strobe_low_q;
  logic       strobe_start;
  logic [3:0] acc_cnt;

  assign strobe_low   = !oe_n || !we_n;
  assign strobe_start = strobe_low && !strobe_low_q;

  // accesses started while chip-select has stayed asserted
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_low_q <= 1'b0;
      acc_cnt      <= '0;
    end else begin
      strobe_low_q <= strobe_low;
      if (&cs_n)             acc_cnt <= '0;
      else if (strobe_start) acc_cnt <= acc_cnt + 4'd1;
    end
  end

  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
    strobe_low |-> !(&cs_n));

  p_ready_hold_oe_r9: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !mem_ready) |=> (!oe_n && $stable(mem_addr)));

  p_ready_hold_we_r9: assert property (@(posedge clk) disable iff (rst)
    (!we_n && !mem_ready) |=> (!we_n && $stable(mem_addr)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!strobe_low && $past(strobe_low)));

  p_burst_limit_r8: assert property (@(posedge clk) disable iff (rst)
    !(&cs_n) |-> ((int'(acc_cnt) + int'(strobe_start)) <= BURST_MAX));
endmodule

bind smc_strobe_seq smc_strobe_seq_chk #(
  .NREG(NREG), .AW(AW), .BURST_MAX(BURST_MAX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .done      (done),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr)
);

// File: tb/smc_strobe_seq_tb.sv
module smc_strobe_seq_tb;
  localparam int NREG = 2;
  localparam int AW   = 16;
  localparam int DW   = 32;

  logic            clk;
  logic            rst;
  logic [1:0]      boot_strap;
  logic            cfg_we;
  logic [0:0]      cfg_sel;
  logic [7:0]      cfg_wdata;
  logic            req;
  logic [0:0]      req_region;
  logic [AW-1:0]   req_addr;
  logic            req_write;
  logic [DW-1:0]   req_wdata;
  logic            done;
  logic [DW-1:0]   rdata;
  logic [NREG-1:0] cs_n;
  logic            oe_n;
  logic            we_n;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic [DW-1:0]   mem_rdata;
  logic            mem_ready;

  int n_tests = 0;
  int n_fail  = 0;

  smc_strobe_seq #(.NREG(NREG), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .boot_strap(boot_strap),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .req_region(req_region), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // memory model: read data derived from the address
  assign mem_rdata = {16'hC0DE, mem_addr};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; boot_strap = s; req = 1'b0; cfg_we = 1'b0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    boot_strap = ~s;   // later strap changes must be ignored (R2)
  endtask

  task automatic cfg_write(input int sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access; checks strobes, data, done pulse, strobe length, cs afterwards
  task automatic acc_chk(input int region, input logic [15:0] addr, input bit wr,
                         input int stall, input int exp_low, input bit exp_held,
                         input string tag, output bit pre_rel);
    int stalled = 0;
    int guard = 0;
    int low = 0;
    bit got = 0;
    bit bad = 0;
    bit cs_done_rel = 0;
    logic [31:0] rd = '0;
    logic [31:0] wd = {16'h5A00, addr};
    logic [1:0] exp_cs = (region == 0) ? 2'b10 : 2'b01;
    pre_rel = 0;
    req = 1'b1; req_region = 1'(region); req_addr = addr;
    req_write = wr; req_wdata = wd;
    while (!got && guard < 60) begin
      @(negedge clk);
      guard++;
      if (&cs_n && low == 0) pre_rel = 1;
      if (!oe_n || !we_n) begin
        low++;
        if (wr ? !(!we_n && oe_n) : !(!oe_n && we_n)) bad = 1;
        if (mem_addr != addr || cs_n != exp_cs) bad = 1;
        if (wr && mem_wdata != wd) bad = 1;
        if (stalled < stall) begin mem_ready = 1'b0; stalled++; end
        else mem_ready = 1'b1;
      end
      if (done) begin
        got = 1; rd = rdata; cs_done_rel = &cs_n;
      end
    end
    req = 1'b0; mem_ready = 1'b1;
    check(!bad, {tag, " R4 strobe/addr/cs during access"}, bad, 0);
    check(got, {tag, " R10 done seen"}, got, 1);
    check(low == exp_low, {tag, " R4 strobe cycles"}, low, exp_low);
    if (!wr) check(rd == {16'hC0DE, addr}, {tag, " R10 read data"}, rd, {16'hC0DE, addr});
    if (!exp_held) check(cs_done_rel, {tag, " R8 cs released in done cycle"}, cs_done_rel, 1);
    @(negedge clk);
    check(!done, {tag, " R10 single done pulse"}, done, 0);
    check((cs_n[region] == 1'b0) == exp_held, {tag, " R8 cs held after access"},
          cs_n[region], !exp_held);
  endtask

  task automatic t_reset();
    apply_reset(2'b00);
    check(cs_n == 2'b11, "R1 cs_n idle", cs_n, 3);
    check(oe_n && we_n, "R1 strobes idle", {oe_n, we_n}, 3);
    check(!done, "R1 done low", done, 0);
  endtask

  task automatic t_boot();
    bit pr;
    logic [1:0] codes [3] = '{2'b01, 2'b10, 2'b11};
    int steps [3] = '{1, 2, 4};
    for (int i = 0; i < 3; i++) begin
      apply_reset(codes[i]);
      // region 0: rnd 2, seq 0, page on, width field 11 (must be ignored)
      cfg_write(0, 8'hD2);
      acc_chk(0, 16'h0100, 0, 0, 3, 1, "R2 boot first", pr);
      acc_chk(0, 16'(16'h0100 + steps[i]), 0, 0, 1, 1, "R2 boot sequential step", pr);
    end
  endtask

  task automatic t_burst();
    bit pr;
    apply_reset(2'b00);
    cfg_write(1, 8'h16);   // R3: rnd 2, seq 1, page on, 4 bytes
    acc_chk(1, 16'h1000, 0, 0, 3, 1, "R5 burst 1", pr);
    acc_chk(1, 16'h1004, 0, 0, 2, 1, "R5 burst 2", pr);
    acc_chk(1, 16'h1008, 0, 0, 2, 1, "R5 burst 3", pr);
    acc_chk(1, 16'h100C, 0, 0, 2, 0, "R8 burst 4 releases", pr);
    acc_chk(1, 16'h1010, 0, 0, 3, 1, "R8 new burst random", pr);
    cfg_write(1, 8'h96);   // R3: width code 10 -> 2 bytes
    acc_chk(1, 16'h2000, 0, 0, 3, 1, "R3 width16 first", pr);
    acc_chk(1, 16'h2002, 0, 0, 2, 1, "R3 width16 sequential", pr);
  endtask

  task automatic t_nopage();
    bit pr;
    apply_reset(2'b00);
    cfg_write(1, 8'h01);   // rnd 1, seq 0, page off
    acc_chk(1, 16'h3000, 0, 0, 2, 1, "R6 nopage 1", pr);
    acc_chk(1, 16'h3004, 0, 0, 2, 1, "R6 nopage 2", pr);
    acc_chk(1, 16'h3008, 0, 0, 2, 1, "R6 nopage 3", pr);
    acc_chk(1, 16'h300C, 0, 0, 2, 0, "R8 nopage 4 releases", pr);
  endtask

  task automatic t_nonseq();
    bit pr;
    apply_reset(2'b00);
    cfg_write(1, 8'h16);
    acc_chk(1, 16'h1000, 0, 0, 3, 1, "R5 nonseq first", pr);
    acc_chk(1, 16'h1008, 0, 0, 3, 1, "R5 address gap random", pr);
    acc_chk(1, 16'h100C, 0, 0, 2, 1, "R5 resumes sequential", pr);
  endtask

  task automatic t_writable();
    bit pr;
    apply_reset(2'b00);
    cfg_write(1, 8'h30);   // writable, page on, seq 0, rnd 0
    acc_chk(1, 16'h0040, 1, 0, 1, 1, "R7 write random", pr);
    acc_chk(1, 16'h0044, 1, 0, 2, 1, "R7 write seq forced wait", pr);
    cfg_write(1, 8'h10);   // same but not writable
    acc_chk(1, 16'h0048, 1, 0, 1, 1, "R7 non-writable seq zero", pr);
  endtask

  task automatic t_ready();
    bit pr;
    apply_reset(2'b00);
    cfg_write(1, 8'h00);
    acc_chk(1, 16'h0500, 0, 3, 4, 1, "R9 stall beyond zero wait", pr);
    cfg_write(1, 8'h02);
    acc_chk(1, 16'h0600, 0, 1, 3, 1, "R9 stall within waits", pr);
    acc_chk(1, 16'h0700, 1, 4, 5, 1, "R9 stall on write", pr);
  endtask

  task automatic t_switch();
    bit pr;
    apply_reset(2'b00);
    acc_chk(1, 16'h0010, 0, 0, 4, 1, "R3 default region1", pr);
    acc_chk(0, 16'h0020, 0, 0, 4, 1, "R11 switch to region0", pr);
    check(pr, "R11 cs released before region change", pr, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; boot_strap = 2'b00; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req = 1'b0; req_region = '0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
    mem_ready = 1'b1;
    t_reset();
    t_boot();
    t_burst();
    t_nopage();
    t_nonseq();
    t_writable();
    t_ready();
    t_switch();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule